// File: doc/BRIEF.md
# Pointer-Designated Scratchpad Register Bank

This block holds a bank of sixteen 16-bit scratchpad registers for a small 8-bit processor core. None of the registers is fixed as program counter or data pointer. A 4-bit program designator names the register that acts as the program counter. A 4-bit data designator names the register that acts as the data pointer. The two values of those registers always appear on dedicated 16-bit outputs, so fetch and memory logic elsewhere can use them directly.

Each cycle, an 8-bit opcode is presented with an execute strobe. The high nibble chooses the operation and the low nibble chooses a register (or a designator value). The supported operations are:

- reading either byte of a register onto a byte output;
- writing an 8-bit data input into either byte;
- stepping a register up or down by one;
- changing either designator;
- packing both designators into an 8-bit save register, for use when an interrupt is taken.

The bank has no memory port and no arithmetic unit beyond the increment and decrement.

The decoded operation is an enumerated kind, selected by a unique case on the high nibble:

| Kind | Effect |
|------|--------|
| OP_NONE | Idle. Taken when the strobe is low or the opcode is not listed. |
| OP_INC | Increment the selected register. |
| OP_DEC | Decrement the selected register. |
| OP_GETLO | Read the low byte. |
| OP_GETHI | Read the high byte. |
| OP_PUTLO | Write the low byte. |
| OP_PUTHI | Write the high byte. |
| OP_SETP | Set the program designator. |
| OP_SETX | Set the data designator. |
| OP_SAVE | Pack both designators into the save register. |

Every kind completes in one clock and returns to accepting a new opcode on the next cycle.

Top module: `ptr_regfile`

## Requirements
- R1: After reset the program designator, data designator, save register, byte output and all sixteen registers are zero, so pc_out, dp_out, t_out and byte_out read 0 and every byte read returns 0.
- R2: Opcode 0xDn sets the program designator to n. From the next cycle, pc_out shows register n.
- R3: Opcode 0xEn sets the data designator to n. From the next cycle, dp_out shows register n.
- R4: Opcode 0x79 loads the save register with the data designator in bits 7:4 and the program designator in bits 3:0, and leaves both designators unchanged.
- R5: Opcode 0x8n loads byte_out with bits 7:0 of register n. Opcode 0x9n loads byte_out with bits 15:8 of register n. Both values are visible on the next cycle.
- R6: Opcode 0xAn writes d_in into bits 7:0 of register n. Opcode 0xBn writes d_in into bits 15:8. In both cases the other byte is unchanged.
- R7: Opcode 0x1n increments register n and opcode 0x2n decrements it, both modulo 65536 (0xFFFF+1 = 0x0000, 0x0000-1 = 0xFFFF).
- R8: When op_valid is low, or when the opcode is none of the above, no register, designator, save register or byte_out changes.
- R9: A write, increment or decrement of the register named by a designator shows on pc_out or dp_out on the next cycle, without the designator being set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Execute strobe for op_code |
| op_code | input | 8 | Operation nibble (7:4) and register nibble (3:0) |
| d_in | input | 8 | Byte written by the put operations |
| byte_out | output | 8 | Byte returned by the most recent get operation |
| pc_out | output | 16 | Value of the register named by the program designator |
| dp_out | output | 16 | Value of the register named by the data designator |
| t_out | output | 8 | Save register: data designator in the high nibble, program designator in the low nibble |

## Verification
The hardest case to reach from the ports is the register that both designators name at once, while that register is being stepped across its wrap point. The stimulus first fills that register to 0xFFFF with two put operations. It then points both designators at it and increments it, so pc_out and dp_out must both wrap together. A separate sequence changes the designators after a save and then issues a save with the strobe low, to show that the save register keeps its earlier packed value.

// File: rtl/ptr_regfile_pkg.sv
package ptr_regfile_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_INC,
        OP_DEC,
        OP_GETLO,
        OP_GETHI,
        OP_PUTLO,
        OP_PUTHI,
        OP_SETP,
        OP_SETX,
        OP_SAVE
    } op_kind_e;

endpackage

// File: rtl/ptr_opdec.sv
module ptr_opdec
    import ptr_regfile_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic            valid,
    input  logic [IW+3:0]   code,
    output op_kind_e        kind,
    output logic [IW-1:0]   idx
);
    localparam int OPW = IW + 4;

    logic [3:0] major;

    assign major = code[OPW-1:OPW-4];
    assign idx   = code[IW-1:0];

    always_comb begin
        kind = OP_NONE;
        if (valid) begin
            unique case (major)
                4'h1:    kind = OP_INC;
                4'h2:    kind = OP_DEC;
                4'h7:    kind = (idx == IW'(9)) ? OP_SAVE : OP_NONE;
                4'h8:    kind = OP_GETLO;
                4'h9:    kind = OP_GETHI;
                4'hA:    kind = OP_PUTLO;
                4'hB:    kind = OP_PUTHI;
                4'hD:    kind = OP_SETP;
                4'hE:    kind = OP_SETX;
                default: kind = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ptr_regarray.sv
module ptr_regarray #(
    parameter int NREG = 16,
    parameter int RW   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd_en,
    input  logic [$clog2(NREG)-1:0]  upd_idx,
    input  logic [RW-1:0]            upd_val,
    input  logic [$clog2(NREG)-1:0]  rd_idx,
    input  logic [$clog2(NREG)-1:0]  p_idx,
    input  logic [$clog2(NREG)-1:0]  x_idx,
    output logic [RW-1:0]            rd_val,
    output logic [RW-1:0]            p_val,
    output logic [RW-1:0]            x_val
);
    localparam int IW = $clog2(NREG);

    logic [RW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (upd_en && upd_idx == IW'(i))
                regs[i] <= upd_val;
        end
    end

    assign rd_val = regs[rd_idx];
    assign p_val  = regs[p_idx];
    assign x_val  = regs[x_idx];
endmodule

// File: rtl/ptr_desig.sv
module ptr_desig
    import ptr_regfile_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  op_kind_e        kind,
    input  logic [IW-1:0]   idx,
    output logic [IW-1:0]   p_q,
    output logic [IW-1:0]   x_q,
    output logic [2*IW-1:0] t_q
);
    logic [IW-1:0]   p_nx, x_nx;
    logic [2*IW-1:0] t_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
            x_q <= '0;
            t_q <= '0;
        end else begin
            p_q <= p_nx;
            x_q <= x_nx;
            t_q <= t_nx;
        end
    end

    always_comb begin
        p_nx = p_q;
        x_nx = x_q;
        t_nx = t_q;
        unique case (kind)
            OP_SETP: p_nx = idx;
            OP_SETX: x_nx = idx;
            OP_SAVE: t_nx = {x_q, p_q};
            default: ;
        endcase
    end

    // R8
    p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != OP_SETP) |=> $stable(p_q));

    // R8
    x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != OP_SETX) |=> $stable(x_q));

    // R4
    save_keeps_desig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == OP_SAVE) |=> ($stable(p_q) && $stable(x_q)));

    // R8
    t_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != OP_SAVE) |=> $stable(t_q));
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
    import ptr_regfile_pkg::*;
#(
    parameter int NREG = 16,
    parameter int RW   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [7:0]  op_code,
    input  logic [7:0]  d_in,
    output logic [7:0]  byte_out,
    output logic [15:0] pc_out,
    output logic [15:0] dp_out,
    output logic [7:0]  t_out
);
    localparam int IW = $clog2(NREG);
    localparam int BW = RW / 2;

    op_kind_e      kind;
    logic [IW-1:0] idx, p_q, x_q;
    logic [RW-1:0] cur, nxt, p_val, x_val;
    logic          upd_en;
    logic [BW-1:0] byte_q;

    ptr_opdec #(.IW(IW)) u_dec (
        .valid (op_valid),
        .code  (op_code),
        .kind  (kind),
        .idx   (idx)
    );

    ptr_desig #(.IW(IW)) u_desig (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .idx   (idx),
        .p_q   (p_q),
        .x_q   (x_q),
        .t_q   (t_out)
    );

    ptr_regarray #(.NREG(NREG), .RW(RW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .upd_idx (idx),
        .upd_val (nxt),
        .rd_idx  (idx),
        .p_idx   (p_q),
        .x_idx   (x_q),
        .rd_val  (cur),
        .p_val   (p_val),
        .x_val   (x_val)
    );

    always_comb begin
        upd_en = 1'b1;
        nxt    = cur;
        unique case (kind)
            OP_INC:   nxt = cur + RW'(1);
            OP_DEC:   nxt = cur - RW'(1);
            OP_PUTLO: nxt = {cur[RW-1:BW], d_in};
            OP_PUTHI: nxt = {d_in, cur[BW-1:0]};
            default:  upd_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            byte_q <= '0;
        else if (kind == OP_GETLO)
            byte_q <= cur[BW-1:0];
        else if (kind == OP_GETHI)
            byte_q <= cur[RW-1:BW];
    end

    assign byte_out = byte_q;
    assign pc_out   = p_val;
    assign dp_out   = x_val;

    // R8
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != OP_GETLO && kind != OP_GETHI) |=> $stable(byte_out));

    // R7
    inc_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == OP_INC && idx == p_q) |=> (pc_out == $past(pc_out) + RW'(1)));

    // R7
    dec_dp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == OP_DEC && idx == x_q) |=> (dp_out == $past(dp_out) - RW'(1)));

    // R9
    untouched_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && kind != OP_SETP) |=> $stable(pc_out));
endmodule

// File: tb/ptr_regfile_test.sv
`timescale 1ns/1ps
module ptr_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic [7:0]  d_in = 8'h00;
    logic [7:0]  byte_out;
    logic [15:0] pc_out, dp_out;
    logic [7:0]  t_out;

    always #2.5 clk = ~clk;

    ptr_regfile uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .d_in     (d_in),
        .byte_out (byte_out),
        .pc_out   (pc_out),
        .dp_out   (dp_out),
        .t_out    (t_out)
    );

    typedef struct {
        logic [15:0] pc;
        logic [15:0] dp;
        logic [7:0]  t;
        logic [7:0]  b;
        string       req;
    } exp_t;

    exp_t expq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    logic [15:0] m_r [16];
    logic [3:0]  m_p, m_x;
    logic [7:0]  m_t, m_b;

    task automatic push_exp(input string req);
        exp_t e;
        e.pc  = m_r[m_p];
        e.dp  = m_r[m_x];
        e.t   = m_t;
        e.b   = m_b;
        e.req = req;
        expq.push_back(e);
    endtask

    task automatic issue(input logic [7:0] op, input logic [7:0] d,
                         input bit v, input string req);
        logic [3:0] n;
        @(negedge clk);
        op_valid = v;
        op_code  = op;
        d_in     = d;
        n = op[3:0];
        if (v) begin
            case (op[7:4])
                4'h1: m_r[n] = m_r[n] + 16'd1;
                4'h2: m_r[n] = m_r[n] - 16'd1;
                4'h7: if (n == 4'h9) m_t = {m_x, m_p};
                4'h8: m_b = m_r[n][7:0];
                4'h9: m_b = m_r[n][15:8];
                4'hA: m_r[n][7:0]  = d;
                4'hB: m_r[n][15:8] = d;
                4'hD: m_p = n;
                4'hE: m_x = n;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        push_exp(req);
    endtask

    // Monitor: compares one expected item per falling edge
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            n_chk++;
            if (pc_out !== e.pc || dp_out !== e.dp || t_out !== e.t || byte_out !== e.b) begin
                n_bad++;
                $display("FAIL %s: actual pc=%h dp=%h t=%h b=%h expected pc=%h dp=%h t=%h b=%h",
                         e.req, pc_out, dp_out, t_out, byte_out, e.pc, e.dp, e.t, e.b);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_r[i] = 16'h0000;
        m_p = 4'h0; m_x = 4'h0; m_t = 8'h00; m_b = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push_exp("R1");                        // reset state
        issue(8'h9F, 8'h00, 1'b1, "R1");       // RF high byte is zero
        issue(8'h85, 8'h00, 1'b1, "R1");       // R5 low byte is zero
        // R6 put bytes, R5 get bytes
        issue(8'hA3, 8'h34, 1'b1, "R6");
        issue(8'hB3, 8'h12, 1'b1, "R6");
        issue(8'h83, 8'h00, 1'b1, "R5");
        issue(8'h93, 8'h00, 1'b1, "R5");
        issue(8'hB3, 8'hAB, 1'b1, "R6");
        issue(8'h83, 8'h00, 1'b1, "R6");       // low byte kept
        // R2 select PC
        issue(8'hD3, 8'h00, 1'b1, "R2");
        issue(8'h13, 8'h00, 1'b1, "R9");       // inc of R(P) shows on pc_out
        // R3 select data pointer
        issue(8'hE3, 8'h00, 1'b1, "R3");
        issue(8'hE5, 8'h00, 1'b1, "R3");
        issue(8'h25, 8'h00, 1'b1, "R7");       // 0000 - 1 = FFFF
        issue(8'h15, 8'h00, 1'b1, "R7");       // FFFF + 1 = 0000
        issue(8'hA5, 8'h77, 1'b1, "R9");       // put low on R(X)
        // R4 save
        issue(8'h79, 8'h00, 1'b1, "R4");
        issue(8'hD7, 8'h00, 1'b1, "R2");
        issue(8'h79, 8'h00, 1'b0, "R8");       // strobe low: T unchanged
        issue(8'h95, 8'h00, 1'b0, "R8");       // strobe low: byte unchanged
        issue(8'hA7, 8'h99, 1'b0, "R8");       // strobe low: no write
        issue(8'h00, 8'h55, 1'b1, "R8");       // unlisted opcodes
        issue(8'h37, 8'h55, 1'b1, "R8");
        issue(8'h7A, 8'h55, 1'b1, "R8");
        issue(8'hF7, 8'h55, 1'b1, "R8");
        issue(8'h87, 8'h00, 1'b1, "R8");       // R7 still zero
        issue(8'h79, 8'h00, 1'b1, "R4");
        // both designators on one register, wrap together
        issue(8'hAC, 8'hFF, 1'b1, "R6");
        issue(8'hBC, 8'hFF, 1'b1, "R6");
        issue(8'hDC, 8'h00, 1'b1, "R2");
        issue(8'hEC, 8'h00, 1'b1, "R3");
        issue(8'h1C, 8'h00, 1'b1, "R7");
        issue(8'h2C, 8'h00, 1'b1, "R7");
        issue(8'h9C, 8'h00, 1'b1, "R5");
        issue(8'h79, 8'h00, 1'b1, "R4");
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule